// File: doc/BRIEF.md
# SPI EEPROM Boot Loader

This block fetches a boot image from an external SPI serial EEPROM once, right after reset, and hands it on as a stream of bytes. No host is involved. When reset is released it samples a port-type pin and the requested image length. If the SPI type is selected and the length is non-zero, it pulls chip select low. It then shifts out a read opcode and a fixed start address, and clocks in the requested number of bytes back to back within that one chip-select window.

Each received byte appears on an 8-bit output with a single-cycle valid strobe. One cycle after the last strobe a done pulse is raised. Chip select is released on the next falling edge of the serial clock, and the port then stays idle until the next reset. The serial clock comes from a clock-enable divider on the system clock, and it rests low whenever chip select is inactive.

Top module: `spi_boot_master`

## Requirements
- R1: While rst_ni is low, spi_cs_no is 1, spi_sck_o is 0, boot_valid_o is 0 and boot_done_o is 0.
- R2: If port_mode_i is 0 and boot_len_i is non-zero in the first cycle after reset release, chip select goes low in that cycle. The first 8 bits shifted out on spi_mosi_o are the read opcode 8'h03, most significant bit first.
- R3: The opcode is followed by a 16-bit start address of 16'h0000, most significant bit first, for 24 header bits in all.
- R4: Exactly N bytes are read, where N is boot_len_i as sampled in the first cycle after reset release; later changes to boot_len_i have no effect. The bytes come from consecutive addresses within a single chip-select window. Each byte is assembled with the first received bit as bit 7 and is shown on boot_byte_o with a one-cycle boot_valid_o strobe.
- R5: spi_miso_i is sampled when spi_sck_o rises. While chip select is held low, spi_mosi_o changes only in the cycle in which spi_sck_o falls.
- R6: boot_done_o pulses exactly once, one cycle after the last strobe. Chip select rises on the next falling clock edge. After that, chip select, the serial clock and the strobe stay inactive and spi_miso_i is ignored until reset.
- R7: If port_mode_i is 1 at reset release, chip select never asserts, no byte is delivered and no done pulse is raised.
- R8: The spi_sck_o period is 2*DIV_HALF system clocks, with a high phase of DIV_HALF clocks.
- R9: spi_sck_o is 0 whenever spi_cs_no is 1.
- R10: If boot_len_i is 0 at reset release with port_mode_i 0, chip select never asserts and a single done pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_mode_i | input | 1 | Port type select, 0 = SPI, sampled at reset release |
| boot_len_i | input | LEN_W | Number of bytes to read, sampled at reset release |
| spi_cs_no | output | 1 | EEPROM chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Command and address to EEPROM |
| spi_miso_i | input | 1 | Data from EEPROM |
| boot_byte_o | output | 8 | Received byte |
| boot_valid_o | output | 1 | One-cycle strobe for boot_byte_o |
| boot_done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The hardest behaviour to reach from the ports is the permanent lock after the image has been loaded. The port must stay silent even though spi_miso_i keeps toggling and nothing except reset can wake it. The bench lets an EEPROM model finish a full read. It waits for chip select to release, then toggles a noise term on the data line for a long window while watching chip select, the clock and the strobe. A second awkward case is a length change after reset release: the bench changes boot_len_i in the middle of the header and expects the originally sampled count.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CMD,
    ST_DATA,
    ST_STOP,
    ST_LOCK
  } boot_state_e;

  localparam logic [7:0] READ_OPCODE = 8'h03;
endpackage

// File: rtl/spi_boot_sck_gen.sv
module spi_boot_sck_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic sck_q;
  logic wrap;

  generate
    if (DIV_HALF == 1) begin : g_nodiv
      assign wrap = 1'b1;
    end else begin : g_div
      logic [CNT_W-1:0] cnt_q;
      assign wrap = (cnt_q == CNT_W'(DIV_HALF - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sck_q <= 1'b0;
    else if (!run_i) sck_q <= 1'b0;
    else if (wrap)   sck_q <= ~sck_q;
  end

  assign sck_o  = sck_q;
  assign rise_o = run_i && wrap && !sck_q;
  assign fall_o = run_i && wrap && sck_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_o); // R9
endmodule

// File: rtl/spi_boot_shift.sv
module spi_boot_shift #(
  parameter int TX_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TX_W-1:0] load_val_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            miso_i,
  output logic            mosi_o,
  output logic [7:0]      rx_next_o
);
  logic [TX_W-1:0] tx_q;
  logic [7:0]      rx_q;

  // outgoing bits advance on falling clock, incoming bits captured on rising
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '0;
    else if (load_i) tx_q <= load_val_i;
    else if (fall_i) tx_q <= {tx_q[TX_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (rise_i) rx_q <= {rx_q[6:0], miso_i};
  end

  assign mosi_o    = tx_q[TX_W-1];
  assign rx_next_o = {rx_q[6:0], miso_i};
endmodule

// File: rtl/spi_boot_ctrl.sv
module spi_boot_ctrl
  import spi_boot_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int HDR_BITS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [7:0]       rx_next_i,
  output logic             cs_n_o,
  output logic             run_o,
  output logic             load_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic             done_o
);
  localparam int HC_W = $clog2(HDR_BITS);

  boot_state_e      state_q;
  logic [HC_W-1:0]  hdr_cnt_q;
  logic [2:0]       bit_cnt_q;
  logic [LEN_W-1:0] byte_idx_q;
  logic [LEN_W-1:0] len_q;
  logic             cs_n_q;
  logic [7:0]       byte_q;
  logic             valid_q;
  logic             last_q;
  logic             done_q;
  logic             mode_q;
  logic             start_ok;

  assign start_ok = !mode_i && (len_i != '0);
  assign load_o   = (state_q == ST_WAIT) && start_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT;
      hdr_cnt_q  <= '0;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      len_q      <= '0;
      cs_n_q     <= 1'b1;
      byte_q     <= '0;
      valid_q    <= 1'b0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= valid_q && last_q;
      case (state_q)
        ST_WAIT: begin
          mode_q <= mode_i;
          len_q  <= len_i;
          if (start_ok) begin
            state_q <= ST_CMD;
            cs_n_q  <= 1'b0;
          end else begin
            state_q <= ST_LOCK;
            done_q  <= !mode_i;
          end
        end
        ST_CMD: begin
          if (rise_i) begin
            if (hdr_cnt_q == HC_W'(HDR_BITS - 1)) begin
              state_q   <= ST_DATA;
              hdr_cnt_q <= '0;
            end else begin
              hdr_cnt_q <= hdr_cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (rise_i) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == 3'd7) begin
              byte_q  <= rx_next_i;
              valid_q <= 1'b1;
              if (byte_idx_q == len_q - 1'b1) begin
                last_q  <= 1'b1;
                state_q <= ST_STOP;
              end else begin
                byte_idx_q <= byte_idx_q + 1'b1;
              end
            end
          end
        end
        ST_STOP: begin
          // release select together with the falling clock
          if (fall_i) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_LOCK;
          end
        end
        default: ;
      endcase
    end
  end

  assign cs_n_o       = cs_n_q;
  assign run_o        = (state_q == ST_CMD) || (state_q == ST_DATA) || (state_q == ST_STOP);
  assign byte_o       = byte_q;
  assign byte_valid_o = valid_q;
  assign done_o       = done_q;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (len_q != '0)) |-> $past(byte_valid_o)); // R6
  AST_MODE_HIGH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> cs_n_o); // R7
  AST_LOCK_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK) |=> ((state_q == ST_LOCK) && cs_n_o)); // R6
endmodule

// File: rtl/spi_boot_master.sv
module spi_boot_master
  import spi_boot_pkg::*;
#(
  parameter int             DIV_HALF   = 4,
  parameter int             ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = '0,
  parameter int             LEN_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_mode_i,
  input  logic [LEN_W-1:0] boot_len_i,
  output logic             spi_cs_no,
  output logic             spi_sck_o,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i,
  output logic [7:0]       boot_byte_o,
  output logic             boot_valid_o,
  output logic             boot_done_o
);
  localparam int HDR_BITS = 8 + ADDR_W;

  logic            run, rise, fall, load;
  logic [7:0]      rx_next;
  logic [HDR_BITS-1:0] hdr_val;

  assign hdr_val = {READ_OPCODE, START_ADDR};

  spi_boot_sck_gen #(.DIV_HALF(DIV_HALF)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sck_o  (spi_sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_boot_shift #(.TX_W(HDR_BITS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (hdr_val),
    .rise_i     (rise),
    .fall_i     (fall),
    .miso_i     (spi_miso_i),
    .mosi_o     (spi_mosi_o),
    .rx_next_o  (rx_next)
  );

  spi_boot_ctrl #(.LEN_W(LEN_W), .HDR_BITS(HDR_BITS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (port_mode_i),
    .len_i        (boot_len_i),
    .rise_i       (rise),
    .fall_i       (fall),
    .rx_next_i    (rx_next),
    .cs_n_o       (spi_cs_no),
    .run_o        (run),
    .load_o       (load),
    .byte_o       (boot_byte_o),
    .byte_valid_o (boot_valid_o),
    .done_o       (boot_done_o)
  );

  AST_SCK_IDLE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o); // R9
  AST_MOSI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spi_cs_no && $past(!spi_cs_no) && !$fell(spi_sck_o)) |-> $stable(spi_mosi_o)); // R5
endmodule

// File: tb/spi_boot_master_tb.sv
`timescale 1ns/1ps
module spi_boot_master_tb;
  localparam int DH    = 4;
  localparam int LEN_W = 16;
  localparam int WD    = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic port_mode_i = 1'b0;
  logic [LEN_W-1:0] boot_len_i = '0;
  logic spi_cs_no, spi_sck_o, spi_mosi_o, spi_miso_i;
  logic [7:0] boot_byte_o;
  logic boot_valid_o, boot_done_o;

  logic miso_model = 1'b0;
  logic noise = 1'b0;
  assign spi_miso_i = miso_model ^ noise;

  always #4 clk = ~clk;

  spi_boot_master #(.DIV_HALF(DH), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .port_mode_i(port_mode_i), .boot_len_i(boot_len_i),
    .spi_cs_no(spi_cs_no), .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o),
    .spi_miso_i(spi_miso_i), .boot_byte_o(boot_byte_o), .boot_valid_o(boot_valid_o),
    .boot_done_o(boot_done_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  int nbytes, valid_cyc, ndone, done_cyc, cs_falls, post_evt;
  int mosi_err, sck_idle_err, per_err, hi_err, rcnt, last_rise;
  logic [7:0] got [32];
  logic [23:0] hdr;
  logic after_done = 1'b0;
  logic prev_cs_n = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;

  function automatic logic [7:0] exp_byte(int i);
    return 8'(i * 29 + 90) ^ 8'(i >> 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  // EEPROM model
  always @(negedge spi_cs_no) begin
    rcnt = 0;
    hdr = '0;
    last_rise = -1;
  end

  always @(posedge spi_sck_o) begin
    if (!spi_cs_no) begin
      if (rcnt < 24) hdr = {hdr[22:0], spi_mosi_o};
      rcnt++;
      if (last_rise >= 0 && (cyc - last_rise) != 2 * DH) per_err++;
      last_rise = cyc;
    end
  end

  always @(negedge spi_sck_o) begin
    if (last_rise >= 0 && (cyc - last_rise) != DH) hi_err++;
    if (!spi_cs_no && rcnt >= 24) begin
      automatic int idx = (rcnt - 24) / 8;
      automatic int bp  = 7 - ((rcnt - 24) % 8);
      miso_model = exp_byte(idx)[bp];
    end
  end

  // port monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (boot_valid_o) begin
        if (nbytes < 32) got[nbytes] = boot_byte_o;
        nbytes++;
        valid_cyc = cyc;
        if (after_done) post_evt++;
      end
      if (boot_done_o) begin
        ndone++;
        done_cyc = cyc;
      end
      if (after_done && (!spi_cs_no || spi_sck_o)) post_evt++;
      if (spi_cs_no && spi_sck_o) sck_idle_err++;
      if (!spi_cs_no && !prev_cs_n && spi_mosi_o != prev_mosi && !(prev_sck && !spi_sck_o))
        mosi_err++;
      if (prev_cs_n && !spi_cs_no) cs_falls++;
    end
    prev_cs_n = spi_cs_no;
    prev_sck  = spi_sck_o;
    prev_mosi = spi_mosi_o;
  end

  task automatic do_boot(logic mode, int len, int newlen);
    int limit;
    @(negedge clk);
    rst_ni = 1'b0;
    noise = 1'b0;
    after_done = 1'b0;
    port_mode_i = mode;
    boot_len_i = LEN_W'(len);
    nbytes = 0; ndone = 0; cs_falls = 0; post_evt = 0; valid_cyc = -10; done_cyc = -20;
    mosi_err = 0; sck_idle_err = 0; per_err = 0; hi_err = 0;
    rcnt = 0; hdr = '0; last_rise = -1; miso_model = 1'b0;
    repeat (3) @(negedge clk);
    chk(spi_cs_no && !spi_sck_o && !boot_valid_o && !boot_done_o, "R1 reset state",
        {spi_cs_no, spi_sck_o, boot_valid_o, boot_done_o}, 8);
    rst_ni = 1'b1;
    if (newlen != len) begin
      repeat (5) @(negedge clk);
      boot_len_i = LEN_W'(newlen);
    end
    limit = 48 * DH + len * 16 * DH + 200;
    for (int k = 0; k < limit && ndone == 0; k++) @(negedge clk);
    repeat (2 * DH + 2) @(negedge clk);
    after_done = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      noise = ~noise;
    end
    after_done = 1'b0;
  endtask

  task automatic t_single;
    do_boot(1'b0, 1, 1);
    chk(hdr[23:16] == 8'h03, "R2 opcode", hdr[23:16], 3);
    chk(hdr[15:0] == 16'h0000, "R3 address", hdr[15:0], 0);
    chk(nbytes == 1, "R4 byte count", nbytes, 1);
    chk(got[0] == exp_byte(0), "R4 byte 0", got[0], exp_byte(0));
    chk(cs_falls == 1, "R4 single window", cs_falls, 1);
    chk(ndone == 1, "R6 done once", ndone, 1);
    chk(done_cyc == valid_cyc + 1, "R6 done timing", done_cyc, valid_cyc + 1);
    chk(post_evt == 0, "R6 port idle after done", post_evt, 0);
    chk(spi_cs_no == 1'b1, "R6 select released", spi_cs_no, 1);
  endtask

  task automatic t_multi;
    do_boot(1'b0, 5, 5);
    chk(nbytes == 5, "R4 byte count", nbytes, 5);
    for (int i = 0; i < 5; i++)
      chk(got[i] == exp_byte(i), "R4 byte order", got[i], exp_byte(i));
    chk(cs_falls == 1, "R4 single window", cs_falls, 1);
    chk(per_err == 0, "R8 clock period", per_err, 0);
    chk(hi_err == 0, "R8 high phase", hi_err, 0);
    chk(mosi_err == 0, "R5 mosi on falling edge", mosi_err, 0);
    chk(sck_idle_err == 0, "R9 clock low while idle", sck_idle_err, 0);
    chk(hdr == 24'h030000, "R5 header sampled on rise", hdr, 24'h030000);
    chk(post_evt == 0, "R6 miso ignored after done", post_evt, 0);
  endtask

  task automatic t_len_sampled;
    do_boot(1'b0, 3, 9);
    chk(nbytes == 3, "R4 length sampled at release", nbytes, 3);
    chk(got[2] == exp_byte(2), "R4 last byte", got[2], exp_byte(2));
    chk(ndone == 1, "R6 done once", ndone, 1);
  endtask

  task automatic t_mode_high;
    do_boot(1'b1, 4, 4);
    chk(cs_falls == 0, "R7 no select", cs_falls, 0);
    chk(ndone == 0, "R7 no done", ndone, 0);
    chk(nbytes == 0, "R7 no bytes", nbytes, 0);
  endtask

  task automatic t_zero_len;
    do_boot(1'b0, 0, 0);
    chk(cs_falls == 0, "R10 no select", cs_falls, 0);
    chk(ndone == 1, "R10 single done", ndone, 1);
    chk(nbytes == 0, "R10 no bytes", nbytes, 0);
  endtask

  initial begin
    t_single();
    t_multi();
    t_len_sampled();
    t_mode_high();
    t_zero_len();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule